// File: doc/BRIEF.md
# Register Arithmetic Microoperation Unit

This block performs one register-level arithmetic step on two WIDTH-bit operands, `opA` and `opB`. A three-bit select picks one of six operations: sum, difference, bitwise inverse of `opB`, two's-complement negation of `opB`, `opA` plus one, or `opA` minus one. The two remaining select codes pass `opA` through unchanged. Every operation runs through one chain of full-adder cells. A small decoder sets which operands enter the chain, whether the second input is inverted by XOR gates, and what the carry-in is.

The unit has no storage. The caller latches `result`, `carryOut` and `overflow` into its own destination register. `carryOut` is the final carry of the adder chain. `overflow` is the XOR of the carry into the most significant bit and the carry out of it.

Top module: `arithMicroUnit`

## Requirements
- R1: With opSel = 0, result equals (opA + opB) mod 2^WIDTH and carryOut is bit WIDTH of the full sum.
- R2: With opSel = 1, result equals (opA - opB) mod 2^WIDTH, formed as opA + ~opB + 1, and carryOut is 1 exactly when opA >= opB as unsigned values.
- R3: With opSel = 2, result equals the bitwise inverse of opB, carryOut and overflow are 0, and opA has no effect.
- R4: With opSel = 3, result equals ~opB + 1. carryOut is 1 only when opB is zero. overflow is 1 only when opB is the most negative value (MSB set, all other bits clear). opA has no effect.
- R5: With opSel = 4, result equals opA + 1. carryOut is 1 only when opA is all ones. overflow is 1 only when opA is the largest positive value (MSB clear, all other bits set). opB has no effect.
- R6: With opSel = 5, result equals opA - 1. carryOut is 1 unless opA is zero. overflow is 1 only when opA is the most negative value. opB has no effect.
- R7: With opSel = 6 or 7, result equals opA, carryOut and overflow are 0, and opB has no effect.
- R8: For the sum and the difference, overflow is 1 exactly when the two's-complement result does not fit in WIDTH bits. For the sum, this means both operands have the same sign and the result has the other sign. For the difference, it means the operands differ in sign and the result's sign differs from opA.
- R9: The outputs follow the inputs combinationally, with no clock or state. A new input is reflected in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opSel | input | 3 | Operation select: 0 sum, 1 difference, 2 inverse of B, 3 negate B, 4 increment A, 5 decrement A, 6/7 pass A |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| result | output | WIDTH | Operation result |
| carryOut | output | 1 | Final carry out of the adder chain |
| overflow | output | 1 | Signed overflow: carry into MSB XOR carry out of MSB |

## Verification
Assertions are evaluated whenever the inputs change. They compare the ripple chain against a plain arithmetic sum of its conditioned inputs. They also check the result of sum, difference, inverse, negation, increment and decrement against the port operands, and the sign-based overflow rule for sum and difference. The bench scenarios cover the remaining behaviour: the exact carry and overflow values at the corner operands of each operation, the unused operand having no effect, and the two pass-through codes keeping both flags low.

// File: rtl/arith_micro_pkg.sv
package arith_micro_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_INVB = 3'd2,
    OP_NEGB = 3'd3,
    OP_INCA = 3'd4,
    OP_DECA = 3'd5,
    OP_PAS6 = 3'd6,
    OP_PAS7 = 3'd7
  } arithOp_t;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic keepA;    // x input takes opA, otherwise zero
    logic keepB;    // y input takes opB, otherwise zero
    logic invY;     // XOR mask applied to every y bit
    logic carryIn;  // carry into bit 0
  } arithStrobes_t;

endpackage

// File: rtl/arith_full_add.sv
module arith_full_add (
  input  logic xIn,
  input  logic yIn,
  input  logic zIn,
  output logic sumOut,
  output logic carryOut
);
  logic halfSum;
  assign halfSum  = xIn ^ yIn;
  assign sumOut   = halfSum ^ zIn;
  assign carryOut = (zIn & halfSum) | (xIn & yIn);
endmodule

// File: rtl/arith_control.sv
module arith_control
  import arith_micro_pkg::*;
(
  input  logic [2:0]    opSel,
  output arithStrobes_t strobes
);
  arithOp_t opCode;
  assign opCode = arithOp_t'(opSel);

  always_comb begin
    strobes = '{keepA: 1'b1, keepB: 1'b0, invY: 1'b0, carryIn: 1'b0};
    unique case (opCode)
      OP_ADD:  strobes = '{keepA: 1'b1, keepB: 1'b1, invY: 1'b0, carryIn: 1'b0};
      OP_SUB:  strobes = '{keepA: 1'b1, keepB: 1'b1, invY: 1'b1, carryIn: 1'b1};
      OP_INVB: strobes = '{keepA: 1'b0, keepB: 1'b1, invY: 1'b1, carryIn: 1'b0};
      OP_NEGB: strobes = '{keepA: 1'b0, keepB: 1'b1, invY: 1'b1, carryIn: 1'b1};
      OP_INCA: strobes = '{keepA: 1'b1, keepB: 1'b0, invY: 1'b0, carryIn: 1'b1};
      OP_DECA: strobes = '{keepA: 1'b1, keepB: 1'b0, invY: 1'b1, carryIn: 1'b0};
      OP_PAS6, OP_PAS7:
               strobes = '{keepA: 1'b1, keepB: 1'b0, invY: 1'b0, carryIn: 1'b0};
      default: strobes = '{keepA: 1'b1, keepB: 1'b0, invY: 1'b0, carryIn: 1'b0};
    endcase
  end

  // Passing operations must never route opB into the chain
  always_comb begin
    if (opSel[2] && opSel[1]) begin
      AST_PASS_NO_B: assert (!strobes.keepB && !strobes.carryIn) // R7
        else $error("pass op routes B or carry");
    end
  end
endmodule

// File: rtl/arith_datapath.sv
module arith_datapath
  import arith_micro_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  arithStrobes_t    strobes,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sumBits,
  output logic             carryLast,
  output logic             signOvf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] xVec;
  logic [WIDTH-1:0] yRaw;
  logic [WIDTH-1:0] yVec;
  logic [WIDTH:0]   carryChain;

  assign xVec          = strobes.keepA ? opA : '0;
  assign yRaw          = strobes.keepB ? opB : '0;
  assign yVec          = yRaw ^ {WIDTH{strobes.invY}};
  assign carryChain[0] = strobes.carryIn;

  for (genvar bitIdx = 0; bitIdx < WIDTH; bitIdx++) begin : g_cell
    arith_full_add u_cell (
      .xIn     (xVec[bitIdx]),
      .yIn     (yVec[bitIdx]),
      .zIn     (carryChain[bitIdx]),
      .sumOut  (sumBits[bitIdx]),
      .carryOut(carryChain[bitIdx+1])
    );
  end

  assign carryLast = carryChain[WIDTH];
  assign signOvf   = carryChain[WIDTH] ^ carryChain[MSB];

  // The cell chain must agree with a word-level sum of its own inputs
  always_comb begin
    AST_RIPPLE_MATCH: assert ({carryLast, sumBits} ==
                              ({1'b0, xVec} + {1'b0, yVec} + {{WIDTH{1'b0}}, strobes.carryIn})) // R1
      else $error("ripple chain mismatch");
  end
endmodule

// File: rtl/arithMicroUnit.sv
module arithMicroUnit
  import arith_micro_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [2:0]       opSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow
);
  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  arithStrobes_t strobes;

  arith_control u_control (
    .opSel  (opSel),
    .strobes(strobes)
  );

  arith_datapath #(.WIDTH(WIDTH)) u_datapath (
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .sumBits  (result),
    .carryLast(carryOut),
    .signOvf  (overflow)
  );

  always_comb begin
    if (opSel == 3'd0) begin
      AST_ADD_SUM: assert ({carryOut, result} == ({1'b0, opA} + {1'b0, opB})) // R1
        else $error("sum mismatch");
      AST_ADD_OVF: assert (overflow == ((opA[MSB] == opB[MSB]) && (result[MSB] != opA[MSB]))) // R8
        else $error("sum overflow mismatch");
    end
    if (opSel == 3'd1) begin
      AST_SUB_DIFF: assert ((result == opA - opB) && (carryOut == (opA >= opB))) // R2
        else $error("difference mismatch");
      AST_SUB_OVF: assert (overflow == ((opA[MSB] != opB[MSB]) && (result[MSB] != opA[MSB]))) // R8
        else $error("difference overflow mismatch");
    end
    if (opSel == 3'd2) begin
      AST_INV_B: assert ((result == ~opB) && !carryOut && !overflow) // R3
        else $error("inverse mismatch");
    end
    if (opSel == 3'd3) begin
      AST_NEG_B: assert (result == ('0 - opB)) // R4
        else $error("negate mismatch");
    end
    if (opSel == 3'd4) begin
      AST_INC_A: assert (result == opA + ONE) // R5
        else $error("increment mismatch");
    end
    if (opSel == 3'd5) begin
      AST_DEC_A: assert (result == opA - ONE) // R6
        else $error("decrement mismatch");
    end
  end
endmodule

// File: tb/test_arithMicroUnit.sv
`timescale 1ns/1ps
module test_arithMicroUnit;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [2:0]   opSel;
  logic [W-1:0] opA, opB, result;
  logic         carryOut, overflow;

  arithMicroUnit #(.WIDTH(W)) i_arithMicroUnit (
    .opSel(opSel), .opA(opA), .opB(opB),
    .result(result), .carryOut(carryOut), .overflow(overflow)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // {op, a, b, expected result, expected carry, expected overflow}
  localparam int NV = 20;
  localparam logic [52:0] VECS [0:NV-1] = '{
    {3'd0, 16'h1234, 16'h0001, 16'h1235, 1'b0, 1'b0},
    {3'd0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b0},
    {3'd0, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, 1'b1}, // R8
    {3'd0, 16'h8000, 16'h8000, 16'h0000, 1'b1, 1'b1}, // R8
    {3'd0, 16'h1234, 16'h4321, 16'h5555, 1'b0, 1'b0},
    {3'd1, 16'h0005, 16'h0003, 16'h0002, 1'b1, 1'b0},
    {3'd1, 16'h0003, 16'h0005, 16'hFFFE, 1'b0, 1'b0},
    {3'd1, 16'h8000, 16'h0001, 16'h7FFF, 1'b1, 1'b1}, // R8
    {3'd2, 16'h1111, 16'h00FF, 16'hFF00, 1'b0, 1'b0},
    {3'd2, 16'hFFFF, 16'h00FF, 16'hFF00, 1'b0, 1'b0},
    {3'd3, 16'h2222, 16'h0001, 16'hFFFF, 1'b0, 1'b0},
    {3'd3, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 1'b0},
    {3'd3, 16'h0000, 16'h8000, 16'h8000, 1'b0, 1'b1},
    {3'd4, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 1'b0},
    {3'd4, 16'h7FFF, 16'h0000, 16'h8000, 1'b0, 1'b1},
    {3'd4, 16'h0100, 16'hFFFF, 16'h0101, 1'b0, 1'b0},
    {3'd5, 16'h0000, 16'h0000, 16'hFFFF, 1'b0, 1'b0},
    {3'd5, 16'h8000, 16'hFFFF, 16'h7FFF, 1'b1, 1'b1},
    {3'd6, 16'hABCD, 16'h1234, 16'hABCD, 1'b0, 1'b0},
    {3'd7, 16'h5A5A, 16'hFFFF, 16'h5A5A, 1'b0, 1'b0}
  };

  function automatic string tagFor(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic checkOut(input string tag, input logic [W-1:0] expR,
                          input logic expC, input logic expV);
    checks++;
    if (result !== expR || carryOut !== expC || overflow !== expV) begin
      errors++;
      $display("FAIL %s: op=%0d a=%h b=%h got r=%h c=%b v=%b expected r=%h c=%b v=%b",
               tag, opSel, opA, opB, result, carryOut, overflow, expR, expC, expV);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    opSel = op; opA = a; opB = b;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    opSel = 3'd0; opA = '0; opB = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    checkOut("R1 idle zero inputs", 16'h0000, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i][52:50], VECS[i][49:34], VECS[i][33:18]);
      checkOut(tagFor(VECS[i][52:50]), VECS[i][17:2], VECS[i][1], VECS[i][0]);
    end

    // R2: a value minus itself is zero with no borrow
    for (int k = 0; k < 8; k++) begin
      logic [W-1:0] v;
      v = 16'h1357 * k[W-1:0] + 16'h8001;
      apply(3'd1, v, v);
      checkOut("R2 self difference", 16'h0000, 1'b1, 1'b0);
    end

    // R6: decrement away from the corners keeps carry high
    apply(3'd5, 16'h0010, 16'h4444);
    checkOut("R6 mid decrement", 16'h000F, 1'b1, 1'b0);

    // R8: negative plus negative without leaving range
    apply(3'd0, 16'hFFFE, 16'hFFFF);
    checkOut("R8 negative sum fits", 16'hFFFD, 1'b1, 1'b0);

    // R9: a new input shows up before any further clock edge
    @(negedge clk);
    opSel = 3'd4; opA = 16'h00FE; opB = 16'h0000;
    #1;
    checkOut("R9 immediate increment", 16'h00FF, 1'b0, 1'b0);
    opSel = 3'd2; opB = 16'h0F0F;
    #1;
    checkOut("R9 immediate inverse", 16'hF0F0, 1'b0, 1'b0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule